// File: doc/BRIEF.md
# Set-Associative Branch Target Buffer Bank

This block holds fetch-block branch entries in a four-way set-associative array. Each way keeps a 20-bit tag and a 60-bit payload. The prediction side takes a fetch PC in stage 0. The raw ways of the indexed set come back registered in stage 1. In stage 2 the block compares tags, picks the matching way and presents a hit flag, a hit way and the payload. The stage-2 result is registered and shown again in stage 3. There the way number is reported only for a hit.

The update side takes a full entry plus the hit/way meta recorded when the entry was predicted. If the meta says hit, the payload is written straight into the named way. If the meta says miss, the block runs a three-cycle sequence. First it re-reads the set, and this read takes priority over predictions. Next it chooses a way: the way that now hits, else the lowest invalid way, else the tree pseudo-LRU victim. Last it writes that way. A busy output keeps the requester from sending another update while the sequence runs. The array has a single port. Any cycle that uses it for a write or an update read drops the prediction read of that cycle.

Top module: `btb_bank`

## Requirements
- R1: After reset, s2_valid, s3_valid and upd_busy are 0 and every way of every set is invalid, so any lookup misses.
- R2: A prediction driven in cycle c gives its stage-2 result in cycle c+2 with s2_valid=1. The set index is pred_pc[9:1] and the tag is pred_pc[29:10]. A hit is reported when a valid way holds that tag, together with its way number (0..3) and payload.
- R3: In cycle c+3, s3_valid, s3_hit and s3_entry repeat the stage-2 values of cycle c+2. s3_way equals the stage-2 way on a hit and is 0 otherwise.
- R4: An update with upd_meta_hit=1 writes its tag and payload into way upd_meta_way of the indexed set at the end of the cycle it is presented, and upd_busy stays 0.
- R5: An update with upd_meta_hit=0 holds upd_busy at 1 for exactly the two cycles after it is accepted. Its write lands at the end of the second of them.
- R6: If the re-read of a miss update finds its tag valid in the set, that way is overwritten.
- R7: Otherwise, if some way in the set is invalid, the lowest-numbered invalid way is written.
- R8: Otherwise the tree pseudo-LRU victim is written. The tree has root bit b0 (1 = victim among ways 2/3) and leaf bits b1 (ways 0/1, 1 = way 1) and b2 (ways 2/3, 1 = way 3). Touching way w sets b0 to point away from w's pair and sets w's leaf bit to point to its sibling. All bits start at 0.
- R9: Every stage-2 prediction hit touches the hit way, and every write touches the written way.
- R10: A prediction presented in a cycle in which the array is written or re-read for an update is dropped: s2_valid is 0 two cycles later.
- R11: upd_valid is ignored while upd_busy is 1.
- R12: A lookup misses when the tag matches but the index differs, or when the index matches but the tag differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | Prediction lookup request (stage 0) |
| pred_pc | input | 29 | Fetch PC bits 29..1 |
| upd_valid | input | 1 | Update request |
| upd_pc | input | 29 | Update PC bits 29..1 |
| upd_meta_hit | input | 1 | Entry hit at prediction time |
| upd_meta_way | input | 2 | Way that hit at prediction time |
| upd_entry | input | 60 | Entry payload to store |
| upd_busy | output | 1 | Miss-update sequence in progress |
| s2_valid | output | 1 | Stage-2 result is from a performed lookup |
| s2_hit | output | 1 | Stage-2 hit |
| s2_way | output | 2 | Stage-2 hit way |
| s2_entry | output | 60 | Stage-2 payload (don't-care on miss) |
| s3_valid | output | 1 | Stage-3 result valid |
| s3_hit | output | 1 | Stage-3 hit |
| s3_way | output | 2 | Stage-3 hit way, 0 on miss |
| s3_entry | output | 60 | Stage-3 payload (don't-care on miss) |

## Verification
The bench fills one set through miss updates and then drives it through every allocation path. A design that picks the wrong empty way puts entries out of order. A design whose pseudo-LRU ignores prediction touches evicts a recently hit entry instead of the way the tree points to. A design that skips the re-read hit check leaves two copies of one tag. A further test sends a prediction in the same cycle as a write, and again during the update's read and write cycles. A design without the port arbitration reports a stale lookup as valid. Another test offers an update while busy. A design that does not ignore it writes a stray tag that later hits. The final reset must wipe all entries, which catches valid bits kept in storage that has no reset.

// File: rtl/btb_pkg.sv
package btb_pkg;
    localparam int BTB_SETS   = 512;
    localparam int BTB_WAYS   = 4;
    localparam int BTB_TAG_W  = 20;
    localparam int BTB_DATA_W = 60;
    localparam int BTB_IDX_W  = $clog2(BTB_SETS);
    localparam int BTB_WAY_W  = $clog2(BTB_WAYS);
    localparam int PC_LO      = 1;
    localparam int TAG_LO     = PC_LO + BTB_IDX_W;
    localparam int PC_HI      = TAG_LO + BTB_TAG_W - 1;

    typedef struct packed {
        logic                  vld;
        logic [BTB_TAG_W-1:0]  tag;
        logic [BTB_DATA_W-1:0] data;
    } way_t;

    typedef enum logic [1:0] {
        UP_IDLE = 2'd0,
        UP_CMP  = 2'd1,
        UP_WR   = 2'd2
    } upd_st_e;
endpackage

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int SETS = BTB_SETS,
    parameter int WAYS = BTB_WAYS,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  re,
    input  logic                  we,
    input  logic [IDX_W-1:0]      idx,
    input  logic [WAY_W-1:0]      wway,
    input  logic [BTB_TAG_W-1:0]  wtag,
    input  logic [BTB_DATA_W-1:0] wdata,
    output way_t [WAYS-1:0]       rd_ways
);
    logic [BTB_TAG_W-1:0]  tag_mem  [SETS][WAYS];
    logic [BTB_DATA_W-1:0] data_mem [SETS][WAYS];
    logic [WAYS-1:0]       vld_q    [SETS];
    logic [BTB_TAG_W-1:0]  rtag_q   [WAYS];
    logic [BTB_DATA_W-1:0] rdata_q  [WAYS];
    logic [WAYS-1:0]       rvld_q;

    // payload storage has no reset, like a plain SRAM macro
    always_ff @(posedge clk) begin
        if (we) begin
            tag_mem[idx][wway]  <= wtag;
            data_mem[idx][wway] <= wdata;
        end
        if (re) begin
            for (int w = 0; w < WAYS; w++) begin
                rtag_q[w]  <= tag_mem[idx][w];
                rdata_q[w] <= data_mem[idx][w];
            end
        end
    end

    // valid bits live in flops so reset can clear the whole array
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
            rvld_q <= '0;
        end else begin
            if (we) vld_q[idx][wway] <= 1'b1;
            if (re) rvld_q <= vld_q[idx];
        end
    end

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_out
            assign rd_ways[g] = '{vld: rvld_q[g], tag: rtag_q[g], data: rdata_q[g]};
        end
    endgenerate
endmodule

// File: rtl/btb_plru.sv
module btb_plru
    import btb_pkg::*;
#(
    parameter int SETS = BTB_SETS,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ta_en,
    input  logic [IDX_W-1:0] ta_idx,
    input  logic [1:0]       ta_way,
    input  logic             tb_en,
    input  logic [IDX_W-1:0] tb_idx,
    input  logic [1:0]       tb_way,
    input  logic [IDX_W-1:0] q_idx,
    output logic [1:0]       victim
);
    // tree for four ways: [0] root, [1] ways 0/1, [2] ways 2/3
    logic [2:0] bits_q [SETS];
    logic [2:0] bits_d [SETS];

    function automatic logic [2:0] touch(input logic [2:0] b, input logic [1:0] w);
        logic [2:0] r;
        r    = b;
        r[0] = ~w[1];
        if (w[1]) r[2] = ~w[0];
        else      r[1] = ~w[0];
        return r;
    endfunction

    always_comb begin
        bits_d = bits_q;
        if (ta_en) bits_d[ta_idx] = touch(bits_d[ta_idx], ta_way);
        if (tb_en) bits_d[tb_idx] = touch(bits_d[tb_idx], tb_way);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) bits_q[s] <= '0;
        end else begin
            bits_q <= bits_d;
        end
    end

    assign victim = bits_q[q_idx][0] ? {1'b1, bits_q[q_idx][2]} : {1'b0, bits_q[q_idx][1]};
endmodule

// File: rtl/btb_bank.sv
module btb_bank
    import btb_pkg::*;
#(
    parameter int SETS = BTB_SETS,
    parameter int WAYS = BTB_WAYS,
    localparam int IDX_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pred_valid,
    input  logic [PC_HI:PC_LO]    pred_pc,
    input  logic                  upd_valid,
    input  logic [PC_HI:PC_LO]    upd_pc,
    input  logic                  upd_meta_hit,
    input  logic [WAY_W-1:0]      upd_meta_way,
    input  logic [BTB_DATA_W-1:0] upd_entry,
    output logic                  upd_busy,
    output logic                  s2_valid,
    output logic                  s2_hit,
    output logic [WAY_W-1:0]      s2_way,
    output logic [BTB_DATA_W-1:0] s2_entry,
    output logic                  s3_valid,
    output logic                  s3_hit,
    output logic [WAY_W-1:0]      s3_way,
    output logic [BTB_DATA_W-1:0] s3_entry
);
    typedef struct packed {
        upd_st_e               st;
        logic [PC_HI:PC_LO]    upd_pc;
        logic [BTB_DATA_W-1:0] upd_ent;
        logic [WAY_W-1:0]      tgt_way;
        logic                  s1_pred;
        logic [PC_HI:PC_LO]    s1_pc;
        logic                  s2_valid;
        logic [PC_HI:PC_LO]    s2_pc;
        way_t [WAYS-1:0]       s2_ways;
        logic                  s3_valid;
        logic                  s3_hit;
        logic [WAY_W-1:0]      s3_way;
        logic [BTB_DATA_W-1:0] s3_ent;
    } bank_reg_t;

    bank_reg_t q, d;

    function automatic logic [IDX_W-1:0] idx_of(input logic [PC_HI:PC_LO] pc);
        return pc[TAG_LO-1:PC_LO];
    endfunction
    function automatic logic [BTB_TAG_W-1:0] tag_of(input logic [PC_HI:PC_LO] pc);
        return pc[PC_HI:TAG_LO];
    endfunction

    logic                  accept, imm_wr, upd_rd, late_wr, mem_we, mem_re, pred_go;
    logic [IDX_W-1:0]      mem_idx, w_idx;
    logic [WAY_W-1:0]      w_way, victim;
    logic [BTB_TAG_W-1:0]  w_tag;
    logic [BTB_DATA_W-1:0] w_data;
    way_t [WAYS-1:0]       rd_ways;
    logic [WAYS-1:0]       s2_hv, rr_hv, rr_free;
    logic [WAY_W-1:0]      s2_way_c, rr_way, free_way;

    btb_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
        .clk(clk), .rst_n(rst_n), .re(mem_re), .we(mem_we), .idx(mem_idx),
        .wway(w_way), .wtag(w_tag), .wdata(w_data), .rd_ways(rd_ways)
    );

    btb_plru #(.SETS(SETS)) u_plru (
        .clk(clk), .rst_n(rst_n),
        .ta_en(s2_hit), .ta_idx(idx_of(q.s2_pc)), .ta_way(s2_way_c),
        .tb_en(mem_we), .tb_idx(w_idx), .tb_way(w_way),
        .q_idx(idx_of(q.upd_pc)), .victim(victim)
    );

    always_comb begin
        d = q;
        // port arbitration: write, then update re-read, then prediction
        accept  = upd_valid && (q.st == UP_IDLE);
        imm_wr  = accept && upd_meta_hit;
        upd_rd  = accept && !upd_meta_hit;
        late_wr = (q.st == UP_WR);
        mem_we  = imm_wr || late_wr;
        pred_go = pred_valid && !mem_we && !upd_rd;
        mem_re  = upd_rd || pred_go;
        w_idx   = imm_wr ? idx_of(upd_pc) : idx_of(q.upd_pc);
        w_tag   = imm_wr ? tag_of(upd_pc) : tag_of(q.upd_pc);
        w_data  = imm_wr ? upd_entry : q.upd_ent;
        w_way   = imm_wr ? upd_meta_way : q.tgt_way;
        mem_idx = mem_we ? w_idx : (upd_rd ? idx_of(upd_pc) : idx_of(pred_pc));

        // stage 2 compare on registered ways, lowest way wins
        s2_way_c = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            s2_hv[w] = q.s2_ways[w].vld && (q.s2_ways[w].tag == tag_of(q.s2_pc));
            if (s2_hv[w]) s2_way_c = WAY_W'(w);
        end

        // update re-read: hit way, else first free way, else victim
        rr_way   = '0;
        free_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            rr_hv[w]   = rd_ways[w].vld && (rd_ways[w].tag == tag_of(q.upd_pc));
            rr_free[w] = !rd_ways[w].vld;
            if (rr_hv[w])   rr_way   = WAY_W'(w);
            if (rr_free[w]) free_way = WAY_W'(w);
        end

        d.s1_pred  = pred_go;
        d.s1_pc    = pred_pc;
        d.s2_valid = q.s1_pred;
        d.s2_pc    = q.s1_pc;
        d.s2_ways  = rd_ways;
        d.s3_valid = q.s2_valid;
        d.s3_hit   = q.s2_valid && (|s2_hv);
        d.s3_way   = (q.s2_valid && (|s2_hv)) ? s2_way_c : '0;
        d.s3_ent   = q.s2_ways[s2_way_c].data;

        case (q.st)
            UP_IDLE: if (upd_rd) begin
                d.st      = UP_CMP;
                d.upd_pc  = upd_pc;
                d.upd_ent = upd_entry;
            end
            UP_CMP: begin
                d.st      = UP_WR;
                d.tgt_way = (|rr_hv) ? rr_way : ((|rr_free) ? free_way : victim);
            end
            default: d.st = UP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign upd_busy = (q.st != UP_IDLE);
    assign s2_valid = q.s2_valid;
    assign s2_hit   = q.s2_valid && (|s2_hv);
    assign s2_way   = s2_way_c;
    assign s2_entry = q.s2_ways[s2_way_c].data;
    assign s3_valid = q.s3_valid;
    assign s3_hit   = q.s3_hit;
    assign s3_way   = q.s3_way;
    assign s3_entry = q.s3_ent;

    // R10
    pred_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !q.s1_pred);
    // R3
    s3_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s2_valid |=> (s3_valid && (s3_hit == $past(s2_hit)) && (s3_entry == $past(s2_entry))));
    // R3
    s3_way_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s3_hit |-> (s3_way == '0));
    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(upd_busy) |=> upd_busy);
    // R5
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_busy && $past(upd_busy)) |=> !upd_busy);
endmodule

// File: tb/sim_btb_bank.sv
`timescale 1ns/1ps
module sim_btb_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pred_valid = 1'b0;
    logic [29:1] pred_pc = '0;
    logic        upd_valid = 1'b0;
    logic [29:1] upd_pc = '0;
    logic        upd_meta_hit = 1'b0;
    logic [1:0]  upd_meta_way = '0;
    logic [59:0] upd_entry = '0;
    logic        upd_busy, s2_valid, s2_hit, s3_valid, s3_hit;
    logic [1:0]  s2_way, s3_way;
    logic [59:0] s2_entry, s3_entry;
    int nchk = 0;
    int nerr = 0;

    always #4 clk = ~clk;

    btb_bank u0 (.*);

    typedef struct packed {
        logic [1:0]  op;    // 0 miss update, 1 hit update, 2 lookup
        logic [19:0] tag;
        logic [8:0]  idx;
        logic [1:0]  way;
        logic [59:0] ent;
        logic        hit;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t TBL [NV] = '{
        '{2'd0, 20'h1A001, 9'd5, 2'd0, 60'hA1, 1'b0, 4'd7},  // R7
        '{2'd2, 20'h1A001, 9'd5, 2'd0, 60'hA1, 1'b1, 4'd7},  // R7 way0
        '{2'd0, 20'h2B002, 9'd5, 2'd0, 60'hB1, 1'b0, 4'd7},
        '{2'd0, 20'h3C003, 9'd5, 2'd0, 60'hC1, 1'b0, 4'd7},
        '{2'd0, 20'h4D004, 9'd5, 2'd0, 60'hD1, 1'b0, 4'd7},
        '{2'd2, 20'h2B002, 9'd5, 2'd1, 60'hB1, 1'b1, 4'd7},  // R7 way1
        '{2'd2, 20'h3C003, 9'd5, 2'd2, 60'hC1, 1'b1, 4'd2},  // R2
        '{2'd2, 20'h4D004, 9'd5, 2'd3, 60'hD1, 1'b1, 4'd2},
        '{2'd0, 20'h5E005, 9'd5, 2'd0, 60'hE1, 1'b0, 4'd8},  // R8 victim way0
        '{2'd2, 20'h1A001, 9'd5, 2'd0, 60'h0,  1'b0, 4'd8},  // R8 evicted
        '{2'd2, 20'h5E005, 9'd5, 2'd0, 60'hE1, 1'b1, 4'd8},
        '{2'd0, 20'h2B002, 9'd5, 2'd0, 60'hB2, 1'b0, 4'd6},  // R6 re-read hit
        '{2'd2, 20'h2B002, 9'd5, 2'd1, 60'hB2, 1'b1, 4'd6},
        '{2'd0, 20'h6F006, 9'd5, 2'd0, 60'hF1, 1'b0, 4'd8},  // R8 victim way2
        '{2'd2, 20'h3C003, 9'd5, 2'd0, 60'h0,  1'b0, 4'd8},
        '{2'd2, 20'h6F006, 9'd5, 2'd2, 60'hF1, 1'b1, 4'd8},
        '{2'd2, 20'h5E005, 9'd5, 2'd0, 60'hE1, 1'b1, 4'd9},  // R9 touch way0
        '{2'd0, 20'h81008, 9'd5, 2'd0, 60'h81, 1'b0, 4'd9},  // R9 victim way3
        '{2'd2, 20'h81008, 9'd5, 2'd3, 60'h81, 1'b1, 4'd9},
        '{2'd2, 20'h5E005, 9'd5, 2'd0, 60'hE1, 1'b1, 4'd9},
        '{2'd1, 20'h70007, 9'd5, 2'd1, 60'h71, 1'b0, 4'd4},  // R4 direct write
        '{2'd2, 20'h70007, 9'd5, 2'd1, 60'h71, 1'b1, 4'd4},
        '{2'd2, 20'h2B002, 9'd5, 2'd0, 60'h0,  1'b0, 4'd4},
        '{2'd2, 20'h5E005, 9'd6, 2'd0, 60'h0,  1'b0, 4'd12}, // R12 other index
        '{2'd2, 20'h5E00F, 9'd5, 2'd0, 60'h0,  1'b0, 4'd12}, // R12 other tag
        '{2'd0, 20'h1A001, 9'd6, 2'd0, 60'hA6, 1'b0, 4'd7},
        '{2'd2, 20'h1A001, 9'd6, 2'd0, 60'hA6, 1'b1, 4'd7}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [19:0] tag, input logic [8:0] idx, input logic ehit,
                          input logic [1:0] eway, input logic [59:0] eent, input string req);
        @(negedge clk);
        pred_valid = 1'b1;
        pred_pc    = {tag, idx};
        @(negedge clk);
        pred_valid = 1'b0;
        @(negedge clk);
        check({req, " R2 s2_valid"}, 64'(s2_valid), 64'd1);
        check({req, " s2_hit"}, 64'(s2_hit), 64'(ehit));
        if (ehit) begin
            check({req, " s2_way"}, 64'(s2_way), 64'(eway));
            check({req, " s2_entry"}, 64'(s2_entry), 64'(eent));
        end
        @(negedge clk);
        check({req, " R3 s3_hit"}, 64'(s3_hit), 64'(ehit));
        check({req, " R3 s3_way"}, 64'(s3_way), ehit ? 64'(eway) : 64'd0);
        if (ehit) check({req, " R3 s3_entry"}, 64'(s3_entry), 64'(eent));
    endtask

    task automatic upd_miss(input logic [19:0] tag, input logic [8:0] idx, input logic [59:0] ent);
        @(negedge clk);
        upd_valid    = 1'b1;
        upd_meta_hit = 1'b0;
        upd_pc       = {tag, idx};
        upd_entry    = ent;
        @(negedge clk);
        upd_valid = 1'b0;
        check("R5 busy cycle 1", 64'(upd_busy), 64'd1);
        @(negedge clk);
        check("R5 busy cycle 2", 64'(upd_busy), 64'd1);
        @(negedge clk);
        check("R5 busy released", 64'(upd_busy), 64'd0);
    endtask

    task automatic upd_hit(input logic [19:0] tag, input logic [8:0] idx, input logic [1:0] way,
                           input logic [59:0] ent);
        @(negedge clk);
        upd_valid    = 1'b1;
        upd_meta_hit = 1'b1;
        upd_meta_way = way;
        upd_pc       = {tag, idx};
        upd_entry    = ent;
        @(negedge clk);
        upd_valid = 1'b0;
        check("R4 busy stays low", 64'(upd_busy), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 s2_valid", 64'(s2_valid), 64'd0);
        check("R1 s3_valid", 64'(s3_valid), 64'd0);
        check("R1 upd_busy", 64'(upd_busy), 64'd0);
        lookup(20'h1A001, 9'd5, 1'b0, 2'd0, 60'h0, "R1 empty after reset");

        for (int i = 0; i < NV; i++) begin
            case (TBL[i].op)
                2'd0: upd_miss(TBL[i].tag, TBL[i].idx, TBL[i].ent);
                2'd1: upd_hit(TBL[i].tag, TBL[i].idx, TBL[i].way, TBL[i].ent);
                default: lookup(TBL[i].tag, TBL[i].idx, TBL[i].hit, TBL[i].way, TBL[i].ent,
                                $sformatf("row %0d R%0d", i, TBL[i].req));
            endcase
        end

        // R11: an update offered while busy is ignored
        @(negedge clk);
        upd_valid = 1'b1; upd_meta_hit = 1'b0; upd_pc = {20'h9A009, 9'd7}; upd_entry = 60'h91;
        @(negedge clk);
        upd_meta_hit = 1'b1; upd_meta_way = 2'd2; upd_pc = {20'hAB00A, 9'd7}; upd_entry = 60'h92;
        @(negedge clk);
        upd_valid = 1'b0;
        @(negedge clk);
        check("R11 busy released", 64'(upd_busy), 64'd0);
        lookup(20'hAB00A, 9'd7, 1'b0, 2'd0, 60'h0, "R11 ignored update absent");
        lookup(20'h9A009, 9'd7, 1'b1, 2'd0, 60'h91, "R11 original update stored");

        // R10: prediction collides with a direct write
        @(negedge clk);
        upd_valid = 1'b1; upd_meta_hit = 1'b1; upd_meta_way = 2'd0;
        upd_pc = {20'hBC00B, 9'd9}; upd_entry = 60'hB9;
        pred_valid = 1'b1; pred_pc = {20'hBC00B, 9'd9};
        @(negedge clk);
        upd_valid = 1'b0; pred_valid = 1'b0;
        @(negedge clk);
        check("R10 dropped on write", 64'(s2_valid), 64'd0);

        // R10: prediction during update re-read and during update write
        @(negedge clk);
        upd_valid = 1'b1; upd_meta_hit = 1'b0; upd_pc = {20'hCD00C, 9'd10}; upd_entry = 60'hCA;
        pred_valid = 1'b1; pred_pc = {20'hBC00B, 9'd9};
        @(negedge clk);
        upd_valid = 1'b0; pred_valid = 1'b0;
        check("R5 busy in sequence", 64'(upd_busy), 64'd1);
        @(negedge clk);
        check("R10 dropped on re-read", 64'(s2_valid), 64'd0);
        pred_valid = 1'b1;
        @(negedge clk);
        pred_valid = 1'b0;
        check("R5 busy cleared", 64'(upd_busy), 64'd0);
        @(negedge clk);
        check("R10 dropped on late write", 64'(s2_valid), 64'd0);
        lookup(20'hBC00B, 9'd9, 1'b1, 2'd0, 60'hB9, "R4 direct write visible");
        lookup(20'hCD00C, 9'd10, 1'b1, 2'd0, 60'hCA, "R7 miss update stored");

        // R1: reset clears stored entries
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", 64'(upd_busy), 64'd0);
        check("R1 s3_valid after reset", 64'(s3_valid), 64'd0);
        lookup(20'h5E005, 9'd5, 1'b0, 2'd0, 60'h0, "R1 entries cleared");

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule